// File: doc/BRIEF.md
# PWM Angle Frame Encoder

This block turns a 12-bit angle into a one-wire pulse-width frame. Time is measured in PWM periods, and a one-cycle tick input marks the end of each period. A frame always spans 4119 periods. It opens with a fixed high lead-in of 12 periods. A 4-period flag field follows, which is high when the frame is healthy. Next comes a 4095-period data field, whose leading high part is as long as the angle value. The frame closes with 8 low periods. A receiver recovers the angle by measuring the high time and subtracting 16 periods.

A fault input replaces the frame with a short marker: only the 12 lead-in periods are high, and everything after them stays low. The angle and the fault flag are captured once, when a frame begins, and they govern that whole frame. An enable input gates the encoder. While it is low, the wire stays low and the period counter is cleared, so the first tick after enable opens a fresh frame.

Top module: `pwm_angle_encoder`

## Requirements
- R1: After reset is asserted, `pwm_o` is 0 and no frame is in progress.
- R2: A frame lasts exactly 4119 periods, indexed 0 to 4118. While enabled, period 0 of the next frame follows period 4118 with no gap.
- R3: Periods 0 to 11 of every frame drive `pwm_o` to 1, whether or not a fault is present.
- R4: In a healthy frame, periods 12 to 15 are 1. Data periods 16 to 4110 are 1 for the first A of them and 0 after that, where A is the unsigned value on `angle_i`. The frame therefore holds 16+A high periods.
- R5: The data field covers both ends of the range. A=0 gives no high data period, and A=4095 gives all 4095 data periods high.
- R6: When the captured fault flag is 1, only periods 0 to 11 are high. The flag field and the whole data field are 0, giving 12 high periods per frame.
- R7: `angle_i` and `fault_i` are captured at the tick that opens period 0. Changes to them later in the frame have no effect until the next frame.
- R8: One clock after `en_i` is seen low, `pwm_o` is 0 and the frame position returns to the start. After `en_i` rises again, the first tick opens period 0 of a new frame.
- R9: The frame position advances only on a clock edge where `tick_i` is 1, and `pwm_o` stays constant between such edges.
- R10: Periods 4111 to 4118 are 0 in every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Encoder enable; 0 holds the output low and clears the frame position |
| tick_i | input | 1 | One-cycle pulse that ends the current PWM period |
| angle_i | input | 12 | Angle to encode, unsigned, in PWM periods of data high time |
| fault_i | input | 1 | Diagnostic fault; 1 selects the 12-period marker frame |
| pwm_o | output | 1 | Encoded PWM wire, registered |

## Verification
The assertions check the following on every cycle: the lead-in is high, a captured fault keeps everything after the lead-in low, the output holds between ticks, disable forces the output low and rewinds the position, the position wraps after the last period, and the captured values stay frozen inside a frame. Other behaviours need the bench's scenarios, which compare whole frames period by period against a model. These are the exact high count of 16+A at the ends of the angle range, the timing of a mid-frame change that only takes effect in the following frame, seamless back-to-back frames, and the length of a frame under a slow tick.

// File: rtl/pwmf_pkg.sv
package pwmf_pkg;

    // Default layout of one encoded frame, in PWM periods.
    localparam int ANGLE_BITS   = 12;
    localparam int INIT_PERIODS = 12;
    localparam int FLAG_PERIODS = 4;
    localparam int TAIL_PERIODS = 8;

    // Frame section that a period index falls into.
    typedef enum logic [1:0] {
        SEC_INIT,
        SEC_FLAG,
        SEC_DATA,
        SEC_TAIL
    } pwm_section_e;

endpackage

// File: rtl/pwmf_timer.sv
module pwmf_timer #(
    parameter int FRAME_LEN = 4119,
    parameter int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    output logic [POS_W-1:0] pos_q_o,
    output logic [POS_W-1:0] pos_d_o,
    output logic             run_q_o,
    output logic             start_o
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             run;
    } timer_t;

    timer_t cur_q, nxt_d;
    logic   at_last;

    always_comb begin
        nxt_d   = cur_q;
        at_last = (cur_q.pos == LAST_POS);
        start_o = 1'b0;
        if (!en_i) begin
            nxt_d.pos = '0;
            nxt_d.run = 1'b0;
        end else if (tick_i) begin
            nxt_d.run = 1'b1;
            if (!cur_q.run || at_last) begin
                nxt_d.pos = '0;
                start_o   = 1'b1;
            end else begin
                nxt_d.pos = cur_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pos_q_o = cur_q.pos;
    assign pos_d_o = nxt_d.pos;
    assign run_q_o = cur_q.run;

    // R2: the position never leaves the frame
    a_r2_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_q.pos <= LAST_POS);

    // R2: a tick on the last period wraps to period 0
    a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && tick_i && cur_q.run && cur_q.pos == LAST_POS)
        |=> (cur_q.run && cur_q.pos == '0));

    // R8: disable rewinds the frame position
    a_r8_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!cur_q.run && cur_q.pos == '0));

    // R9: no tick, no movement
    a_r9_pos_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tick_i) |=> $stable(cur_q.pos));

endmodule

// File: rtl/pwmf_sampler.sv
module pwmf_sampler #(
    parameter int ANG_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [ANG_W-1:0] angle_i,
    input  logic             fault_i,
    output logic [ANG_W-1:0] ang_d_o,
    output logic             err_d_o,
    output logic             err_q_o
);

    typedef struct packed {
        logic [ANG_W-1:0] ang;
        logic             err;
    } hold_t;

    hold_t hold_q, hold_d;

    always_comb begin
        hold_d = hold_q;
        if (start_i) begin
            hold_d.ang = angle_i;
            hold_d.err = fault_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign ang_d_o = hold_d.ang;
    assign err_d_o = hold_d.err;
    assign err_q_o = hold_q.err;

    // R7: captured values only change when a frame opens
    a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> ($stable(hold_q.ang) && $stable(hold_q.err)));

endmodule

// File: rtl/pwmf_shaper.sv
module pwmf_shaper
    import pwmf_pkg::*;
#(
    parameter int ANG_W    = 12,
    parameter int INIT_LEN = 12,
    parameter int FLAG_LEN = 4,
    parameter int DATA_LEN = 4095,
    parameter int POS_W    = 13
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic [ANG_W-1:0] ang_i,
    input  logic             fault_i,
    output logic             level_o
);

    localparam logic [POS_W-1:0] INIT_END = POS_W'(INIT_LEN);
    localparam logic [POS_W-1:0] FLAG_END = POS_W'(INIT_LEN + FLAG_LEN);
    localparam logic [POS_W-1:0] DATA_END = POS_W'(INIT_LEN + FLAG_LEN + DATA_LEN);

    pwm_section_e     sec;
    logic [POS_W-1:0] data_idx;
    logic [POS_W-1:0] ang_ext;

    assign ang_ext = POS_W'(ang_i);

    always_comb begin
        if (pos_i < INIT_END) begin
            sec = SEC_INIT;
        end else if (pos_i < FLAG_END) begin
            sec = SEC_FLAG;
        end else if (pos_i < DATA_END) begin
            sec = SEC_DATA;
        end else begin
            sec = SEC_TAIL;
        end
        data_idx = pos_i - FLAG_END;
        unique case (sec)
            SEC_INIT: level_o = 1'b1;
            SEC_FLAG: level_o = !fault_i;
            SEC_DATA: level_o = !fault_i && (data_idx < ang_ext);
            default:  level_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_angle_encoder.sv
module pwm_angle_encoder
    import pwmf_pkg::*;
#(
    parameter int ANG_W    = ANGLE_BITS,
    parameter int INIT_LEN = INIT_PERIODS,
    parameter int FLAG_LEN = FLAG_PERIODS,
    parameter int TAIL_LEN = TAIL_PERIODS
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [ANG_W-1:0] angle_i,
    input  logic             fault_i,
    output logic             pwm_o
);

    localparam int DATA_LEN  = (1 << ANG_W) - 1;
    localparam int FRAME_LEN = INIT_LEN + FLAG_LEN + DATA_LEN + TAIL_LEN;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] INIT_END = POS_W'(INIT_LEN);

    typedef struct packed {
        logic out;
    } wire_t;

    logic [POS_W-1:0] pos_q, pos_d;
    logic             run_q, start;
    logic [ANG_W-1:0] ang_d;
    logic             err_d, err_q;
    logic             level;
    wire_t            wire_q, wire_d;

    pwmf_timer #(
        .FRAME_LEN (FRAME_LEN),
        .POS_W     (POS_W)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .tick_i  (tick_i),
        .pos_q_o (pos_q),
        .pos_d_o (pos_d),
        .run_q_o (run_q),
        .start_o (start)
    );

    pwmf_sampler #(
        .ANG_W (ANG_W)
    ) u_sampler (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .angle_i (angle_i),
        .fault_i (fault_i),
        .ang_d_o (ang_d),
        .err_d_o (err_d),
        .err_q_o (err_q)
    );

    pwmf_shaper #(
        .ANG_W    (ANG_W),
        .INIT_LEN (INIT_LEN),
        .FLAG_LEN (FLAG_LEN),
        .DATA_LEN (DATA_LEN),
        .POS_W    (POS_W)
    ) u_shaper (
        .pos_i   (pos_d),
        .ang_i   (ang_d),
        .fault_i (err_d),
        .level_o (level)
    );

    always_comb begin
        wire_d = wire_q;
        if (!en_i) begin
            wire_d.out = 1'b0;
        end else if (tick_i) begin
            wire_d.out = level;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wire_q <= '0;
        end else begin
            wire_q <= wire_d;
        end
    end

    assign pwm_o = wire_q.out;

    // R8: disable drives the wire low on the next clock
    a_r8_out_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !pwm_o);

    // R9: the wire only moves on a tick
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tick_i) |=> $stable(pwm_o));

    // R3: the lead-in periods are always high
    a_r3_init_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && pos_q < INIT_END) |-> pwm_o);

    // R6: a captured fault keeps everything after the lead-in low
    a_r6_fault_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && err_q && pos_q >= INIT_END) |-> !pwm_o);

    // R1: idle encoder keeps the wire low
    a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_q |-> !pwm_o);

endmodule

// File: tb/pwm_angle_encoder_test.sv
module pwm_angle_encoder_test;

    localparam int FRAME = 4119;
    localparam int LAST  = FRAME - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        tick = 1'b0;
    logic [11:0] angle = '0;
    logic        fault = 1'b0;
    logic        pwm;

    int checks = 0;
    int fails  = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    int cycles = 0;
    logic last_s = 1'b0;
    int hold_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwm_angle_encoder uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .en_i    (en),
        .tick_i  (tick),
        .angle_i (angle),
        .fault_i (fault),
        .pwm_o   (pwm)
    );

    // Tick generator, driven away from the active edge.
    always @(negedge clk) begin
        if (tick_div <= 1) begin
            tick <= 1'b1;
        end else begin
            tick_cnt <= (tick_cnt + 1) % tick_div;
            tick <= (tick_cnt == tick_div - 1);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic model(input int p, input int a, input bit e);
        if (p < 12) return 1'b1;
        if (p < 16) return !e;
        if (p < 16 + 4095) return !e && ((p - 16) < a);
        return 1'b0;
    endfunction

    // Waits for the next tick edge, checking that the wire held before it.
    task automatic next_period();
        bit seen;
        forever begin
            @(posedge clk);
            seen = tick;
            @(negedge clk);
            if (seen) break;
            if (pwm !== last_s) hold_bad++;
        end
        last_s = pwm;
    endtask

    task automatic enable_fresh(input int a, input bit e);
        @(negedge clk);
        en = 1'b0;
        angle = 12'(a);
        fault = e;
        repeat (3) @(negedge clk);
        last_s = 1'b0;
        en = 1'b1;
    endtask

    // One whole frame compared period by period; optional input change at chg_at.
    task automatic check_frame(input int a, input bit e, input int chg_at,
                               input int a2, input bit e2, input string tag);
        int mism = 0;
        int highs = 0;
        int first_p = -1;
        int first_v = 0;
        hold_bad = 0;
        for (int p = 0; p < FRAME; p++) begin
            next_period();
            if (pwm !== model(p, a, e)) begin
                if (first_p < 0) begin
                    first_p = p;
                    first_v = int'(pwm);
                end
                mism++;
            end
            if (pwm === 1'b1) highs++;
            if (p == chg_at) begin
                angle = 12'(a2);
                fault = e2;
            end
        end
        check(mism == 0, {tag, " pattern mismatches (first at period shown as actual)"},
              first_p, -1);
        check(highs == (e ? 12 : 16 + a), {tag, " high periods"}, highs, e ? 12 : 16 + a);
        check(hold_bad == 0, {tag, " R9 hold between ticks"}, hold_bad, 0);
    endtask

    task automatic t_reset();
        #1;
        check(pwm === 1'b0, "R1 output during reset", int'(pwm), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(pwm === 1'b0, "R1 output idle after reset", int'(pwm), 0);
    endtask

    // R2 R4 R5 R10: back-to-back frames, the new angle set during the last period.
    task automatic t_normal();
        enable_fresh(0, 1'b0);
        check_frame(0, 1'b0, LAST, 1000, 1'b0, "R5 R2 angle 0");
        check_frame(1000, 1'b0, LAST, 4095, 1'b0, "R4 R2 angle 1000");
        check_frame(4095, 1'b0, -1, 0, 1'b0, "R5 R10 angle 4095");
    endtask

    task automatic t_fault();
        enable_fresh(2500, 1'b1);
        check_frame(2500, 1'b1, LAST, 4095, 1'b1, "R6 fault angle 2500");
        check_frame(4095, 1'b1, -1, 0, 1'b0, "R6 fault angle 4095");
    endtask

    // R7: inputs changed inside a frame act only from the next frame.
    task automatic t_midframe();
        enable_fresh(200, 1'b0);
        check_frame(200, 1'b0, 50, 3000, 1'b1, "R7 change angle and fault mid-frame");
        check_frame(3000, 1'b1, 10, 5, 1'b0, "R7 new values take effect next frame");
        check_frame(5, 1'b0, -1, 0, 1'b0, "R7 cleared fault next frame");
    endtask

    task automatic t_disable();
        enable_fresh(300, 1'b0);
        for (int p = 0; p < 10; p++) next_period();
        check(pwm === 1'b1, "R3 lead-in high before disable", int'(pwm), 1);
        en = 1'b0;
        @(negedge clk);
        check(pwm === 1'b0, "R8 low one clock after disable", int'(pwm), 0);
        repeat (6) @(negedge clk);
        check(pwm === 1'b0, "R8 stays low while disabled", int'(pwm), 0);
        enable_fresh(700, 1'b0);
        check_frame(700, 1'b0, -1, 0, 1'b0, "R8 restart from period 0");
    endtask

    // R9: slow tick, one period every three clocks.
    task automatic t_slow();
        int n = 0;
        tick_div = 3;
        enable_fresh(1234, 1'b0);
        check_frame(1234, 1'b0, -1, 0, 1'b0, "R9 slow tick frame");
        hold_bad = 0;
        while (n < 12) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        check(pwm === 1'b1, "R2 R3 next frame lead-in under slow tick", int'(pwm), 1);
        tick_div = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_normal();
        t_fault();
        t_midframe();
        t_disable();
        t_slow();
        finish_run();
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 190000);
                finish_run();
            end
        end
    end

endmodule